// File: doc/BRIEF.md
# Registered/Combinational Output Macrocell Bank

This block is a bank of output cells of the kind found at the pins of a registered programmable logic device. Each cell receives one sum term from an external AND-OR array. It drives its pin either from a D flip-flop that samples that term on the rising clock edge, or straight from the term with the flip-flop bypassed. A per-cell polarity bit can invert what reaches the pin. A per-cell enable term decides whether the pin is driven. The pin is modelled as a value plus a drive flag.

Two global terms act on every flip-flop. The clear term empties the bank to 0 at once, with no clock. The preset term fills the bank with 1s, but only on a rising edge. The flip-flop state always returns to the array as feedback, so a state machine built around the bank keeps stepping while its pins are released. The configuration bits are static levels and are not clocked. A synchronous active-high reset also empties the bank.

Top module: `pld_macrocell_bank`

## Requirements
- R1: When `cfg_reg[i]` is 0, `pin_val[i]` equals `sop_term[i]` XOR `cfg_inv[i]` in the same cycle, with no clock edge needed.
- R2: At each rising edge with `areset_term`, `rst` and `spreset_term` all low, every flip-flop loads its `sop_term` bit, and `fb` shows the loaded value. This happens in both modes.
- R3: While `areset_term` is high, all flip-flops and `fb` are 0 immediately, without waiting for a clock edge.
- R4: `spreset_term` high at a rising edge sets every flip-flop to 1. Before that edge, asserting it leaves `fb` unchanged.
- R5: When `cfg_reg[i]` is 1, `pin_val[i]` equals flip-flop i XOR `cfg_inv[i]`. The inversion sits after the flip-flop, so with `cfg_inv[i]` = 1 the pin shows the complement of the captured value.
- R6: `pin_drive[i]` equals `oe_term[i]` in the same cycle. `pin_val[i]` is meaningful only while `pin_drive[i]` is 1.
- R7: With every `oe_term` bit low, the flip-flops still load each cycle and `fb` keeps advancing.
- R8: Priority at an edge is `areset_term` over `rst` over `spreset_term` over the normal load. With `rst` and `spreset_term` both high, the bank goes to 0.
- R9: `rst` high at a rising edge clears every flip-flop to 0.
- R10: A change of `cfg_reg` or `cfg_inv` changes `pin_val` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears the flip-flops |
| sop_term | input | CELLS | Sum term from the array, one per cell |
| oe_term | input | CELLS | Output-enable term, one per cell |
| areset_term | input | 1 | Global asynchronous clear term, active high |
| spreset_term | input | 1 | Global synchronous preset term, active high |
| cfg_reg | input | CELLS | 1 selects registered output, 0 selects bypass |
| cfg_inv | input | CELLS | 1 inverts the pin value |
| pin_val | output | CELLS | Value presented at each pin |
| pin_drive | output | CELLS | 1 when the pin is driven |
| fb | output | CELLS | Flip-flop state returned to the array |

## Verification
Bypass-mode pin values, drive flags, configuration changes and the asynchronous clear have no register in their path. They are checked one time unit after the inputs change at the falling edge, inside the same cycle. Flip-flop results have exactly one register in their path: the load, the preset, the reset and registered pin values. They are checked one time unit after the next rising edge, against a bench model that is updated at that edge. To confirm that nothing moves early, the preset and clear cases also sample `fb` between the input change and the edge.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  // Action taken by the flip-flops at a rising edge
  typedef enum logic [1:0] {
    ACT_LOAD   = 2'd0,
    ACT_PRESET = 2'd1,
    ACT_CLEAR  = 2'd2
  } cell_act_t;
endpackage

// File: rtl/olmc_ctrl.sv
module olmc_ctrl
  import pld_cell_pkg::*;
(
  input  logic      rst,
  input  logic      spreset_term,
  output cell_act_t act
);
  // Synchronous reset outranks the preset term; the load is the default
  always_comb begin
    if (rst)               act = ACT_CLEAR;
    else if (spreset_term) act = ACT_PRESET;
    else                   act = ACT_LOAD;
  end
endmodule

// File: rtl/olmc_state.sv
module olmc_state
  import pld_cell_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spreset_term,
  input  logic             aclr,
  input  cell_act_t        act,
  input  logic [CELLS-1:0] d,
  output logic [CELLS-1:0] q
);
  localparam logic [CELLS-1:0] ALL_ONES = {CELLS{1'b1}};

  for (genvar i = 0; i < CELLS; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or posedge aclr) begin
      if (aclr) begin
        bit_q <= 1'b0;
      end else begin
        case (act)
          ACT_CLEAR:  bit_q <= 1'b0;
          ACT_PRESET: bit_q <= 1'b1;
          default:    bit_q <= d[i];
        endcase
      end
    end
    assign q[i] = bit_q;
  end

  AST_CLEAR_HOLDS: assert property (@(posedge clk)
    aclr |-> q == '0); // R3

  AST_PRESET_FILLS: assert property (@(posedge clk) disable iff (aclr)
    (spreset_term && !rst) |=> q == ALL_ONES); // R4

  AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (aclr)
    (!rst && !spreset_term) |=> q == $past(d)); // R2

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (aclr)
    rst |=> q == '0); // R8
endmodule

// File: rtl/olmc_pinmux.sv
module olmc_pinmux #(
  parameter int CELLS = 8
) (
  input  logic [CELLS-1:0] sop,
  input  logic [CELLS-1:0] state,
  input  logic [CELLS-1:0] cfg_reg,
  input  logic [CELLS-1:0] cfg_inv,
  input  logic [CELLS-1:0] oe,
  output logic [CELLS-1:0] pin_val,
  output logic [CELLS-1:0] pin_drive
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic pre_pol;
    // Polarity is applied after the register/bypass choice
    assign pre_pol      = cfg_reg[i] ? state[i] : sop[i];
    assign pin_val[i]   = pre_pol ^ cfg_inv[i];
    assign pin_drive[i] = oe[i];
  end
endmodule

// File: rtl/pld_macrocell_bank.sv
module pld_macrocell_bank
  import pld_cell_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] sop_term,
  input  logic [CELLS-1:0] oe_term,
  input  logic             areset_term,
  input  logic             spreset_term,
  input  logic [CELLS-1:0] cfg_reg,
  input  logic [CELLS-1:0] cfg_inv,
  output logic [CELLS-1:0] pin_val,
  output logic [CELLS-1:0] pin_drive,
  output logic [CELLS-1:0] fb
);
  cell_act_t        act;
  logic [CELLS-1:0] state;

  olmc_ctrl u_ctrl (
    .rst          (rst),
    .spreset_term (spreset_term),
    .act          (act)
  );

  olmc_state #(.CELLS(CELLS)) u_state (
    .clk          (clk),
    .rst          (rst),
    .spreset_term (spreset_term),
    .aclr         (areset_term),
    .act          (act),
    .d            (sop_term),
    .q            (state)
  );

  olmc_pinmux #(.CELLS(CELLS)) u_mux (
    .sop       (sop_term),
    .state     (state),
    .cfg_reg   (cfg_reg),
    .cfg_inv   (cfg_inv),
    .oe        (oe_term),
    .pin_val   (pin_val),
    .pin_drive (pin_drive)
  );

  // Feedback ignores the pin enables
  assign fb = state;

  AST_REG_PIN_PATH: assert property (@(posedge clk) disable iff (areset_term)
    (!rst && !spreset_term) |=>
      ((pin_val ^ cfg_inv) & cfg_reg) == ($past(sop_term) & cfg_reg)); // R5

  AST_FB_FREE_RUN: assert property (@(posedge clk) disable iff (areset_term)
    (!rst && !spreset_term && oe_term == '0) |=> fb == $past(sop_term)); // R7
endmodule

// File: tb/sim_pld_macrocell_bank.sv
module sim_pld_macrocell_bank;
  localparam int N     = 8;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] sop_term, oe_term, cfg_reg, cfg_inv;
  logic         areset_term, spreset_term;
  logic [N-1:0] pin_val, pin_drive, fb;

  int n_checks = 0;
  int n_fail   = 0;
  logic [N-1:0] model;

  pld_macrocell_bank #(.CELLS(N)) u0 (
    .clk(clk), .rst(rst), .sop_term(sop_term), .oe_term(oe_term),
    .areset_term(areset_term), .spreset_term(spreset_term),
    .cfg_reg(cfg_reg), .cfg_inv(cfg_inv),
    .pin_val(pin_val), .pin_drive(pin_drive), .fb(fb)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [N-1:0] want_pin(logic [N-1:0] st, logic [N-1:0] s,
                                            logic [N-1:0] r, logic [N-1:0] v);
    logic [N-1:0] src;
    for (int i = 0; i < N; i++) src[i] = r[i] ? st[i] : s[i];
    return src ^ v;
  endfunction

  function automatic logic [N-1:0] next_state(logic [N-1:0] st, logic [N-1:0] s,
                                              logic ar, logic r, logic p);
    if (ar) return '0;
    if (r)  return '0;
    if (p)  return '1;
    return s;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // One cycle: drive at the falling edge, check combinational results, then registered ones
  task automatic cycle(logic [N-1:0] s, logic [N-1:0] oe, logic [N-1:0] r,
                       logic [N-1:0] v, logic ar, logic rs, logic p, string tag);
    @(negedge clk);
    sop_term = s; oe_term = oe; cfg_reg = r; cfg_inv = v;
    areset_term = ar; rst = rs; spreset_term = p;
    #1;
    if (ar) model = '0;
    check({tag, " R3/R4 fb before edge"}, fb, model);
    check({tag, " R1/R10 pin same cycle"}, pin_val, want_pin(model, s, r, v));
    check({tag, " R6 drive"}, pin_drive, oe);
    @(posedge clk);
    model = next_state(model, s, ar, rs, p);
    #1;
    check({tag, " R2/R8/R9 fb after edge"}, fb, model);
    check({tag, " R5 pin after edge"}, pin_val, want_pin(model, s, r, v));
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [N-1:0] s;
    void'($urandom(32'd2718));
    sop_term = '0; oe_term = '0; cfg_reg = '0; cfg_inv = '0;
    areset_term = 1'b0; spreset_term = 1'b0; rst = 1'b1;
    model = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R9 reset state fb", fb, '0);
    check("R6 reset state drive", pin_drive, '0);

    // R2 capture in every mode, R5 complement with inversion after the flop
    cycle(8'hA5, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, "reg_inv");
    check("R5 complement of captured", pin_val, ~8'hA5);
    cycle(8'h3C, 8'hFF, 8'hFF, 8'h00, 0, 0, 0, "reg_true");
    // R1 bypass and R10 config switch without a clock
    cycle(8'h96, 8'h0F, 8'h00, 8'hF0, 0, 0, 0, "comb");
    @(negedge clk); cfg_inv = 8'h00; #1;
    check("R10 inv change same cycle", pin_val, 8'h96);
    cfg_reg = 8'hFF; #1;
    check("R10 reg change same cycle", pin_val, 8'h96);
    cfg_reg = 8'h00; sop_term = 8'h11; #1;
    check("R1 bypass follows term", pin_val, 8'h11);
    @(posedge clk); model = 8'h11; #1;

    // R4 preset waits for the edge
    cycle(8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 1, "preset");
    check("R4 preset fills", fb, 8'hFF);
    // R3 clear acts mid-cycle
    cycle(8'h5A, 8'hFF, 8'hFF, 8'h00, 1, 0, 0, "aclear");
    check("R3 clear holds", fb, 8'h00);
    // R8 priority
    cycle(8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, 1, "pre_again");
    cycle(8'hFF, 8'h00, 8'hFF, 8'h00, 1, 1, 1, "all_three");
    check("R8 clear over preset", fb, 8'h00);
    cycle(8'hFF, 8'h00, 8'hFF, 8'h00, 0, 0, 1, "pre_3");
    cycle(8'hC3, 8'h00, 8'hFF, 8'h00, 0, 1, 1, "rst_pre");
    check("R8 reset over preset", fb, 8'h00);
    cycle(8'h7E, 8'h00, 8'hFF, 8'h00, 0, 1, 0, "sync_rst");
    check("R9 sync reset", fb, 8'h00);

    // R7 feedback advances with all pins released
    for (int k = 0; k < 6; k++) begin
      s = 8'(k * 37 + 5);
      cycle(s, 8'h00, 8'hFF, 8'h00, 0, 0, 0, "released");
      check("R7 fb advances", fb, s);
    end

    // Constrained random mix
    for (int k = 0; k < 400; k++) begin
      cycle(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
            ($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 8) == 0, "rand");
    end
    report();
  end
endmodule